// File: doc/BRIEF.md
# Two-Input Edge Interval Timer

This block measures how long it takes from one chosen edge condition to another on two asynchronous digital inputs, A and B, and expresses the interval as a number of system clock cycles. Each input is brought into the clock domain through a synchroniser and then edge-detected. A start selector and a stop selector each pick one of six edge conditions (rising, falling or either edge of one of the two inputs). The two selectors decode their codes differently, so that with both at code 0 the block times a rising edge of A to a rising edge of B.

Software drives the block through plain write strobes and read ports. A module enable gates the whole block. An arm control starts one measurement: written 1, it arms; written 0, it disarms and clears the result. After the stop event the done flag rises and the count is held until the block is disarmed. A constant read port gives the clock frequency in hertz, so that software can turn the count into time. Exactly one measurement is taken per arm.

Top module: `edge_interval_timer`

## Requirements
- R1: Start codes select: 0 = A rising, 1 = A falling, 2 = B rising, 3 = B falling, 4 = A either edge, 5 = B either edge.
- R2: Stop codes select: 0 = B rising, 1 = B falling, 2 = A rising, 3 = A falling, 4 = A either edge, 5 = B either edge.
- R3: When an input edge that is the start event and a later input edge that is the stop event are N clock cycles apart, the count reads N.
- R4: done_o rises only after the stop event. While done_o is 1 the count holds. While done_o is 0, count_o reads 0.
- R5: A write of 0 to arm clears done_o and cancels any measurement. A write of 1 arms only when the timer is idle and enabled; otherwise it is ignored.
- R6: Stop events before the start event are ignored. When start and stop name the same edge type, the first occurrence starts the count and the next one stops it.
- R7: Codes 6 and 7 never produce an event, so a timer armed with such a code never completes.
- R8: The count saturates at all ones (2^CNT_W-1) and never wraps.
- R9: clk_freq_o constantly reads the CLK_HZ parameter.
- R10: A write of 0 to enable cancels any measurement and clears done_o. While disabled, arm writes of 1 are ignored. A write of 1 to enable does not arm by itself.
- R11: After reset done_o is 0, count_o is 0, and both select codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_a | input | 1 | Asynchronous input A |
| sig_b | input | 1 | Asynchronous input B |
| en_wr | input | 1 | Write strobe for the module enable |
| en_wdata | input | 1 | Enable value to write |
| arm_wr | input | 1 | Write strobe for the arm control |
| arm_wdata | input | 1 | Arm value to write (1 arm, 0 disarm and clear) |
| start_sel_wr | input | 1 | Write strobe for the start select code |
| start_sel_wdata | input | 3 | Start select code |
| stop_sel_wr | input | 1 | Write strobe for the stop select code |
| stop_sel_wdata | input | 3 | Stop select code |
| done_o | output | 1 | Measurement complete |
| count_o | output | CNT_W | Interval in clock cycles; valid while done_o is 1 |
| clk_freq_o | output | FREQ_W | Clock frequency constant in hertz |

## Verification
The bench builds the block with CNT_W = 8 and CLK_HZ = 100000000. The 8-bit counter makes saturation reachable in a few hundred cycles, which lets the bench check R8 directly. The frequency value makes the constant port easy to compare. Random start and stop codes on opposite inputs with random gaps cover both code maps. Directed runs cover same-type starts and stops, early stop edges, the never codes, and disarm or disable in the middle of a measurement.

// File: rtl/eit_pkg.sv
package eit_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } eit_state_e;

  typedef struct packed {
    logic a_rise;
    logic a_fall;
    logic b_rise;
    logic b_fall;
  } eit_edges_t;

  // Codes 0..3 address a "primary" input first, then the other one.
  // The start map takes A as primary; the stop map takes B.
  // Codes 4/5 are either-edge of A/B in both maps; 6/7 never fire.
  function automatic logic pick_event(input logic [SEL_W-1:0] code,
                                      input logic stop_map,
                                      input eit_edges_t e);
    logic p_rise, p_fall, s_rise, s_fall;
    logic fire;
    p_rise = stop_map ? e.b_rise : e.a_rise;
    p_fall = stop_map ? e.b_fall : e.a_fall;
    s_rise = stop_map ? e.a_rise : e.b_rise;
    s_fall = stop_map ? e.a_fall : e.b_fall;
    case (code)
      3'd0:    fire = p_rise;
      3'd1:    fire = p_fall;
      3'd2:    fire = s_rise;
      3'd3:    fire = s_fall;
      3'd4:    fire = e.a_rise | e.a_fall;
      3'd5:    fire = e.b_rise | e.b_fall;
      default: fire = 1'b0;
    endcase
    return fire;
  endfunction

endpackage

// File: rtl/eit_sync_edge.sv
module eit_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/eit_event_sel.sv
module eit_event_sel
  import eit_pkg::*;
#(
  parameter bit STOP_MAP = 1'b0
) (
  input  eit_edges_t       edges,
  input  logic [SEL_W-1:0] code,
  output logic             evt
);
  always_comb evt = pick_event(code, STOP_MAP, edges);
endmodule

// File: rtl/eit_interval_ctrl.sv
module eit_interval_ctrl
  import eit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             arm_set,
  input  logic             start_evt,
  input  logic             stop_evt,
  output logic             done,
  output logic             counting,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  eit_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (clear) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (arm_set) begin
          state_q <= ST_WAIT;
          cnt_q   <= '0;
        end
        ST_WAIT: if (start_evt) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_inc;
          if (stop_evt) state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign done     = (state_q == ST_DONE);
  assign counting = (state_q == ST_RUN);
  assign cnt      = cnt_q;
endmodule

// File: rtl/edge_interval_timer.sv
module edge_interval_timer
  import eit_pkg::*;
#(
  parameter int          CNT_W       = 32,
  parameter int          FREQ_W      = 32,
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_a,
  input  logic              sig_b,
  input  logic              en_wr,
  input  logic              en_wdata,
  input  logic              arm_wr,
  input  logic              arm_wdata,
  input  logic              start_sel_wr,
  input  logic [SEL_W-1:0]  start_sel_wdata,
  input  logic              stop_sel_wr,
  input  logic [SEL_W-1:0]  stop_sel_wdata,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [FREQ_W-1:0] clk_freq_o
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] pin_v, rise_v, fall_v, evt_v;
  logic [SEL_W-1:0]  sel_q [NUM_IN];
  logic [NUM_IN-1:0] sel_wr_v;
  logic [SEL_W-1:0]  sel_wd [NUM_IN];
  eit_edges_t        edges;
  logic              en_q;
  logic              clear, arm_set;
  logic              start_evt, stop_evt;
  logic              done, counting;
  logic [CNT_W-1:0]  cnt_q;
  logic [SEL_W-1:0]  start_sel_q, stop_sel_q;

  assign pin_v     = {sig_b, sig_a};
  assign sel_wr_v  = {stop_sel_wr, start_sel_wr};
  assign sel_wd[0] = start_sel_wdata;
  assign sel_wd[1] = stop_sel_wdata;

  // Synchroniser and edge detector per input, and one code register
  // and event selector per measurement boundary (0 = start, 1 = stop).
  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_chan
    eit_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_v[gi]),
      .rise (rise_v[gi]),
      .fall (fall_v[gi])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            sel_q[gi] <= '0;
      else if (sel_wr_v[gi]) sel_q[gi] <= sel_wd[gi];
    end

    eit_event_sel #(.STOP_MAP(gi == 1)) u_sel (
      .edges(edges),
      .code (sel_q[gi]),
      .evt  (evt_v[gi])
    );
  end

  assign edges.a_rise = rise_v[0];
  assign edges.a_fall = fall_v[0];
  assign edges.b_rise = rise_v[1];
  assign edges.b_fall = fall_v[1];
  assign start_evt    = evt_v[0];
  assign stop_evt     = evt_v[1];
  assign start_sel_q  = sel_q[0];
  assign stop_sel_q   = sel_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_wr) en_q <= en_wdata;
  end

  assign clear   = (arm_wr & ~arm_wdata) | (en_wr & ~en_wdata);
  assign arm_set = arm_wr & arm_wdata & en_q;

  eit_interval_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .arm_set  (arm_set),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .done     (done),
    .counting (counting),
    .cnt      (cnt_q)
  );

  assign done_o     = done;
  assign count_o    = done ? cnt_q : '0;
  assign clk_freq_o = FREQ_W'(CLK_HZ);
endmodule

// File: rtl/eit_checker.sv
module eit_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_wr,
  input logic             en_wdata,
  input logic             arm_wr,
  input logic             arm_wdata,
  input logic             done_o,
  input logic [CNT_W-1:0] count_o,
  input logic             counting,
  input logic [CNT_W-1:0] cnt_q,
  input logic             start_evt,
  input logic             stop_evt,
  input logic [2:0]       stop_sel_q
);
  logic kill;
  assign kill = (arm_wr && !arm_wdata) || (en_wr && !en_wdata);

  p_done_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(stop_evt));

  p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !kill) |=> (done_o && $stable(count_o)));

  p_arm_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && !arm_wdata) |=> (!done_o && !counting));

  p_start_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(counting) |-> $past(start_evt));

  p_never_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_sel_q >= 3'd6) |-> !stop_evt);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !kill) |=> (cnt_q >= $past(cnt_q)));

  p_en_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !en_wdata) |=> (!done_o && !counting));
endmodule

bind edge_interval_timer eit_checker #(.CNT_W(CNT_W)) u_eit_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_wr     (en_wr),
  .en_wdata  (en_wdata),
  .arm_wr    (arm_wr),
  .arm_wdata (arm_wdata),
  .done_o    (done_o),
  .count_o   (count_o),
  .counting  (counting),
  .cnt_q     (cnt_q),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .stop_sel_q(stop_sel_q)
);

// File: tb/edge_interval_timer_bench.sv
module edge_interval_timer_bench;
  localparam int          CNT_W  = 8;
  localparam int          FREQ_W = 32;
  localparam int unsigned CLK_HZ = 100_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_a = 1'b0, sig_b = 1'b0;
  logic en_wr = 1'b0, en_wdata = 1'b0;
  logic arm_wr = 1'b0, arm_wdata = 1'b0;
  logic start_sel_wr = 1'b0, stop_sel_wr = 1'b0;
  logic [2:0] start_sel_wdata = '0, stop_sel_wdata = '0;
  logic done_o;
  logic [CNT_W-1:0] count_o;
  logic [FREQ_W-1:0] clk_freq_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  edge_interval_timer #(.CNT_W(CNT_W), .FREQ_W(FREQ_W), .CLK_HZ(CLK_HZ)) u_edge_interval_timer (
    .clk(clk), .rst_n(rst_n), .sig_a(sig_a), .sig_b(sig_b),
    .en_wr(en_wr), .en_wdata(en_wdata), .arm_wr(arm_wr), .arm_wdata(arm_wdata),
    .start_sel_wr(start_sel_wr), .start_sel_wdata(start_sel_wdata),
    .stop_sel_wr(stop_sel_wr), .stop_sel_wdata(stop_sel_wdata),
    .done_o(done_o), .count_o(count_o), .clk_freq_o(clk_freq_o)
  );

  function automatic longint exp_count(input int n);
    longint mx = (longint'(1) << CNT_W) - 1;
    return (n > mx) ? mx : longint'(n);
  endfunction

  // input: 0 = A, 1 = B. kind: 0 rising, 1 falling, 2 either
  function automatic int start_in(input int c);  return (c == 0 || c == 1 || c == 4) ? 0 : 1; endfunction
  function automatic int stop_in(input int c);   return (c == 2 || c == 3 || c == 4) ? 0 : 1; endfunction
  function automatic int start_kind(input int c); return (c >= 4) ? 2 : (c % 2); endfunction
  function automatic int stop_kind(input int c);  return (c >= 4) ? 2 : (c % 2); endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic v);
    en_wr = 1'b1; en_wdata = v; tick(1); en_wr = 1'b0;
  endtask
  task automatic wr_arm(input logic v);
    arm_wr = 1'b1; arm_wdata = v; tick(1); arm_wr = 1'b0;
  endtask
  task automatic wr_sel(input int s, input int p);
    start_sel_wr = 1'b1; start_sel_wdata = 3'(s);
    stop_sel_wr = 1'b1;  stop_sel_wdata = 3'(p);
    tick(1);
    start_sel_wr = 1'b0; stop_sel_wr = 1'b0;
  endtask

  task automatic set_in(input int which, input logic v);
    if (which == 0) sig_a = v; else sig_b = v;
  endtask
  task automatic preset(input int which, input int kind);
    if (kind == 0) set_in(which, 1'b0);
    else if (kind == 1) set_in(which, 1'b1);
  endtask
  task automatic make_edge(input int which, input int kind);
    if (kind == 0) set_in(which, 1'b1);
    else if (kind == 1) set_in(which, 1'b0);
    else if (which == 0) sig_a = ~sig_a;
    else sig_b = ~sig_b;
  endtask

  // Disarm, configure, preset levels, arm, then start edge and stop edge n cycles apart.
  task automatic measure(input int s, input int p, input int n);
    wr_arm(1'b0);
    wr_sel(s, p);
    preset(start_in(s), start_kind(s));
    preset(stop_in(p), stop_kind(p));
    tick(5);
    wr_arm(1'b1);
    tick(3);
    make_edge(start_in(s), start_kind(s));
    tick(n);
    make_edge(stop_in(p), stop_kind(p));
    tick(6);
    chk($sformatf("R1 R2 done start=%0d stop=%0d", s, p), longint'(done_o), 1);
    chk($sformatf("R3 count start=%0d stop=%0d", s, p), longint'(count_o), exp_count(n));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(4);
    rst_n = 1'b1;
    tick(2);
    chk("R11 reset done", longint'(done_o), 0);
    chk("R11 reset count", longint'(count_o), 0);
    chk("R9 clock frequency", longint'(clk_freq_o), longint'(CLK_HZ));

    // R10: enable alone does not arm; R11 default codes time A rise to B rise
    wr_en(1'b1);
    sig_a = 1'b1; tick(2); sig_b = 1'b1; tick(6);
    chk("R10 enable does not arm", longint'(done_o), 0);
    sig_a = 1'b0; sig_b = 1'b0; tick(4);
    wr_arm(1'b1); tick(3);
    sig_a = 1'b1; tick(9); sig_b = 1'b1; tick(6);
    chk("R11 default codes A rise to B rise", longint'(count_o), 9);

    // R4/R5: arm 1 while done ignored, count held
    wr_arm(1'b1); tick(4);
    chk("R5 arm while done ignored", longint'(done_o), 1);
    chk("R4 count held while done", longint'(count_o), 9);
    // R5: arm 0 clears
    wr_arm(1'b0); tick(1);
    chk("R5 disarm clears done", longint'(done_o), 0);
    chk("R4 count zero when not done", longint'(count_o), 0);

    // Random: start and stop on opposite inputs
    for (int it = 0; it < 40; it++) begin
      int s = int'($urandom % 6);
      int k = int'($urandom % 3);
      int p;
      int n = 1 + int'($urandom % 80);
      if (start_in(s) == 0) p = (k == 0) ? 0 : (k == 1) ? 1 : 5;
      else                  p = (k == 0) ? 2 : (k == 1) ? 3 : 4;
      measure(s, p, n);
    end

    // R6: stop before start ignored (start A rise, stop B rise)
    wr_arm(1'b0); wr_sel(0, 0);
    sig_a = 1'b0; sig_b = 1'b0; tick(5);
    wr_arm(1'b1); tick(3);
    sig_b = 1'b1; tick(6);
    chk("R6 early stop ignored", longint'(done_o), 0);
    sig_a = 1'b1; tick(10); sig_b = 1'b0; tick(3); sig_b = 1'b1; tick(6);
    chk("R6 count after early stop", longint'(count_o), 13);

    // R6: same type for start and stop (A rise both)
    wr_arm(1'b0); wr_sel(0, 2);
    sig_a = 1'b0; tick(5);
    wr_arm(1'b1); tick(3);
    sig_a = 1'b1; tick(4); sig_a = 1'b0; tick(3); sig_a = 1'b1; tick(6);
    chk("R6 same type second occurrence", longint'(count_o), 7);

    // R1 R2: either edge of B for both
    wr_arm(1'b0); wr_sel(5, 5); tick(5);
    wr_arm(1'b1); tick(3);
    sig_b = ~sig_b; tick(6); sig_b = ~sig_b; tick(6);
    chk("R2 either edge B both", longint'(count_o), 6);

    // R5: arm 1 while counting ignored, R4: count reads zero while running
    wr_arm(1'b0); wr_sel(0, 0);
    sig_a = 1'b0; sig_b = 1'b0; tick(5);
    wr_arm(1'b1); tick(3);
    sig_a = 1'b1; tick(3);
    chk("R4 count zero while running", longint'(count_o), 0);
    wr_arm(1'b1); tick(4);
    sig_b = 1'b1; tick(6);
    chk("R5 arm while counting ignored", longint'(count_o), 8);

    // R7: never codes
    wr_arm(1'b0); wr_sel(0, 6);
    sig_a = 1'b0; tick(5);
    wr_arm(1'b1); tick(3);
    sig_a = 1'b1; tick(3); sig_b = ~sig_b; tick(3); sig_a = 1'b0; tick(3); sig_b = ~sig_b; tick(8);
    chk("R7 stop code 6 never completes", longint'(done_o), 0);
    wr_arm(1'b0); wr_sel(7, 0);
    sig_b = 1'b0; tick(5);
    wr_arm(1'b1); tick(3);
    sig_a = ~sig_a; tick(3); sig_b = 1'b1; tick(3); sig_b = 1'b0; tick(3); sig_b = 1'b1; tick(8);
    chk("R7 start code 7 never completes", longint'(done_o), 0);

    // R8: saturation
    measure(0, 0, 300);

    // R10: disable mid-run cancels; arm ignored while disabled
    wr_arm(1'b0); wr_sel(0, 0);
    sig_a = 1'b0; sig_b = 1'b0; tick(5);
    wr_arm(1'b1); tick(3);
    sig_a = 1'b1; tick(3);
    wr_en(1'b0); tick(2);
    sig_b = 1'b1; tick(6);
    chk("R10 disable cancels measurement", longint'(done_o), 0);
    sig_a = 1'b0; sig_b = 1'b0; tick(4);
    wr_arm(1'b0); wr_arm(1'b1); tick(3);
    sig_a = 1'b1; tick(5); sig_b = 1'b1; tick(6);
    chk("R10 arm ignored while disabled", longint'(done_o), 0);
    wr_en(1'b1);
    measure(2, 2, 11);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule